// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It oversamples the incoming line with a 16x bit-rate enable supplied from outside. It accepts characters of five to eight data bits, followed by an optional parity bit and a stop bit. Each assembled character goes into a small queue. Three error flags ride along with the character in the same queue entry: received break, framing error and parity error.

A status byte reports the error flags in its upper three bits and live receiver and transmitter conditions in its lower five bits. Two error reporting styles are available:

- **Per-character:** the upper bits belong to the character now at the head of the queue.
- **Block:** every error seen since the last error-reset command is held in sticky form.

A single interrupt request follows either "data available" or "queue full", selected by a configuration bit.

Characters leave through a valid/ready read port. `rd_valid` is high whenever the queue holds at least one character, and `rd_data` then shows the oldest character. The head entry is removed on every clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` has no effect while `rd_valid` is low. The serial side cannot be stalled, so back-pressure from the reader shows up as a full queue and then as an overrun.

Top module: `uart_rx_errq`

## Requirements
- R1: After reset, `rd_valid` and `rx_irq` are 0, and `rx_status` equals {3'b000, 1'b0, tx_empty_in, tx_ready_in, 1'b0, 1'b0}.
- R2: `cfg_char_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data is received LSB first, and unused upper bits of `rd_data` read 0.
- R3: With `cfg_parity_mode`=0, one parity bit follows the data. Even parity (`cfg_parity_odd`=0) or odd parity (=1) is checked, and a mismatch sets the parity flag of that character.
- R4: With `cfg_parity_mode`=1, the parity bit is expected to equal `cfg_parity_odd`, and a mismatch sets the parity flag.
- R5: With `cfg_parity_mode`=2 or 3, no parity bit is expected and the stop bit follows the last data bit. The parity flag stays 0.
- R6: A stop bit sampled low sets the framing flag of that character. The receiver then waits for the line to be high again before it looks for a new start bit.
- R7: A low level on the idle line that is no longer low at its mid-bit sample (eighth sample) is discarded, and no character is produced.
- R8: When the data bits, the parity bit (if any) and the stop bit are all 0, exactly one character is stored with data 0 and the break and framing flags set. Nothing more is stored until the line has returned high.
- R9: The queue holds 3 characters in arrival order. A character that arrives while the queue is full is dropped and sets the overrun bit. The stored entries are unchanged, and overrun stays set until an error-reset or receiver-reset command.
- R10: With `cfg_block_err`=0, status bits [7:5] are {break, framing, parity} of the head character. They read 0 when the queue is empty, so they change when that character is read out.
- R11: With `cfg_block_err`=1, status bits [7:5] are the OR of the flags of every character stored since the last clear. `cmd_err_reset` clears them and the overrun bit. `cmd_rx_reset` also empties the queue.
- R12: Status bit 4 is overrun, bit 3 is `tx_empty_in`, bit 2 is `tx_ready_in`, bit 1 is queue full and bit 0 is data available. `rx_irq` equals bit 1 when `cfg_irq_on_full`=1 and bit 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_x16_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_serial | input | 1 | Serial input line, idle high |
| cfg_char_len | input | 2 | Data bits code (5 to 8) |
| cfg_parity_mode | input | 2 | 0 checked, 1 forced, 2/3 none |
| cfg_parity_odd | input | 1 | Odd parity, or forced level |
| cfg_block_err | input | 1 | 1 selects sticky block error flags |
| cfg_irq_on_full | input | 1 | 1: interrupt on full, 0: on data available |
| cmd_err_reset | input | 1 | Pulse clearing sticky errors and overrun |
| cmd_rx_reset | input | 1 | Pulse resetting receiver, queue and errors |
| tx_empty_in | input | 1 | Transmitter empty, shown in status |
| tx_ready_in | input | 1 | Transmitter ready, shown in status |
| rd_valid | output | 1 | Queue holds a character |
| rd_ready | input | 1 | Reader accepts the head character |
| rd_data | output | 8 | Head character |
| rx_status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default oversampling of 16 and a queue depth of 3. It holds the bit-rate enable high on every clock, so one bit lasts sixteen clocks and a full frame takes under two hundred. The depth of three means four back-to-back frames are enough to reach the full, interrupt-on-full and overrun cases. The short bit time also keeps the long break hold and the glitch rejection within a few thousand cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 8;

  typedef struct packed {
    logic                brk;
    logic                fe;
    logic                pe;
    logic [MAX_BITS-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rx_state_e;
endpackage

// File: rtl/uart_rx_bitengine.sv
module uart_rx_bitengine
  import uart_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par_mode,
  input  logic      cfg_par_odd,
  output logic      push_o,
  output rx_entry_t ent_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_LAST = CW'(OVS/2 - 2);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

  logic [SYNC_LEN-1:0]  sync_q;
  logic                 rx_s;
  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [2:0]           idx;
  logic [MAX_BITS-1:0]  shreg;
  logic                 par_bit;
  logic [2:0]           last_idx;
  logic                 has_par;
  logic                 pe_calc;
  logic                 brk_calc;

  assign rx_s     = sync_q[SYNC_LEN-1];
  assign last_idx = 3'd4 + {1'b0, cfg_len};
  assign has_par  = (cfg_par_mode == 2'd0) || (cfg_par_mode == 2'd1);

  always_comb begin
    case (cfg_par_mode)
      2'd0:    pe_calc = ((^shreg) ^ par_bit) != cfg_par_odd;
      2'd1:    pe_calc = par_bit != cfg_par_odd;
      default: pe_calc = 1'b0;
    endcase
    brk_calc = (shreg == '0) && !(has_par && par_bit) && !rx_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      push_o  <= 1'b0;
      ent_o   <= '0;
    end else if (clr) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      push_o  <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx_s) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == MID_LAST) begin
              cnt <= '0;
              if (!rx_s) begin
                state   <= S_DATA;
                idx     <= '0;
                shreg   <= '0;
                par_bit <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == BIT_LAST) begin
              cnt        <= '0;
              shreg[idx] <= rx_s;
              if (idx == last_idx) state <= has_par ? S_PAR : S_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == BIT_LAST) begin
              cnt     <= '0;
              par_bit <= rx_s;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == BIT_LAST) begin
              cnt        <= '0;
              push_o     <= 1'b1;
              ent_o.data <= shreg;
              ent_o.pe   <= pe_calc;
              ent_o.fe   <= !rx_s;
              ent_o.brk  <= brk_calc;
              state      <= rx_s ? S_IDLE : S_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAITHI: begin
            if (rx_s) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);

  // R8
  brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAITHI && $past(state) == S_WAITHI) |-> !push_o);

  // R8
  brk_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && ent_o.brk) |-> (ent_o.fe && ent_o.data == '0));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push_i,
  input  rx_entry_t din,
  input  logic      pop_i,
  output rx_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i && !clr) |=> (count == $past(count)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      err_reset,
  input  logic      push_i,
  input  rx_entry_t push_ent,
  input  rx_entry_t head,
  input  logic      full,
  input  logic      empty,
  input  logic      cfg_block,
  input  logic      cfg_irq_full,
  input  logic      tx_empty,
  input  logic      tx_ready,
  output logic [7:0] status,
  output logic      irq
);
  logic [2:0] acc;
  logic       ovr;
  logic [2:0] err_bits;
  logic [2:0] head_bits;
  logic [2:0] push_bits;

  assign head_bits = empty ? 3'b000 : {head.brk, head.fe, head.pe};
  assign push_bits = {push_ent.brk, push_ent.fe, push_ent.pe};
  assign err_bits  = cfg_block ? acc : head_bits;
  assign status    = {err_bits, ovr, tx_empty, tx_ready, full, !empty};
  assign irq       = cfg_irq_full ? full : !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovr <= 1'b0;
    end else if (clr || err_reset) begin
      acc <= '0;
      ovr <= 1'b0;
    end else if (push_i) begin
      if (full) ovr <= 1'b1;
      else      acc <= acc | push_bits;
    end
  end

  // R11
  blk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !$past(err_reset)) |-> (($past(acc) & ~acc) == 3'b000));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr && !err_reset) |=> ovr);
endmodule

// File: rtl/uart_rx_errq.sv
module uart_rx_errq
  import uart_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DEPTH    = 3,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_x16_tick,
  input  logic       rx_serial,
  input  logic [1:0] cfg_char_len,
  input  logic [1:0] cfg_parity_mode,
  input  logic       cfg_parity_odd,
  input  logic       cfg_block_err,
  input  logic       cfg_irq_on_full,
  input  logic       cmd_err_reset,
  input  logic       cmd_rx_reset,
  input  logic       tx_empty_in,
  input  logic       tx_ready_in,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic [7:0] rx_status,
  output logic       rx_irq
);
  logic      push;
  rx_entry_t push_ent;
  rx_entry_t head;
  logic      q_full, q_empty;

  uart_rx_bitengine #(.OVS(OVS), .SYNC_LEN(SYNC_LEN)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (cmd_rx_reset),
    .tick         (baud_x16_tick),
    .rxd          (rx_serial),
    .cfg_len      (cfg_char_len),
    .cfg_par_mode (cfg_parity_mode),
    .cfg_par_odd  (cfg_parity_odd),
    .push_o       (push),
    .ent_o        (push_ent)
  );

  uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cmd_rx_reset),
    .push_i (push),
    .din    (push_ent),
    .pop_i  (rd_ready),
    .head   (head),
    .full   (q_full),
    .empty  (q_empty)
  );

  uart_rx_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (cmd_rx_reset),
    .err_reset    (cmd_err_reset),
    .push_i       (push),
    .push_ent     (push_ent),
    .head         (head),
    .full         (q_full),
    .empty        (q_empty),
    .cfg_block    (cfg_block_err),
    .cfg_irq_full (cfg_irq_on_full),
    .tx_empty     (tx_empty_in),
    .tx_ready     (tx_ready_in),
    .status       (rx_status),
    .irq          (rx_irq)
  );

  assign rd_valid = !q_empty;
  assign rd_data  = head.data;

  // R1
  valid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cmd_rx_reset) |=> rd_valid);
endmodule

// File: tb/test_uart_rx_errq.sv
module test_uart_rx_errq;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_pm = 2'd2;
  logic       cfg_odd = 1'b0;
  logic       cfg_blk = 1'b0;
  logic       cfg_irqf = 1'b0;
  logic       err_rst = 1'b0;
  logic       rx_rst = 1'b0;
  logic       tx_e = 1'b1;
  logic       tx_r = 1'b1;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_errq i_uart_rx_errq (
    .clk(clk), .rst_n(rst_n), .baud_x16_tick(tick), .rx_serial(rxd),
    .cfg_char_len(cfg_len), .cfg_parity_mode(cfg_pm), .cfg_parity_odd(cfg_odd),
    .cfg_block_err(cfg_blk), .cfg_irq_on_full(cfg_irqf),
    .cmd_err_reset(err_rst), .cmd_rx_reset(rx_rst),
    .tx_empty_in(tx_e), .tx_ready_in(tx_r),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rx_status(status), .rx_irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit par_on,
                            input logic pbit, input logic stop);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (par_on) line_bit(pbit);
    line_bit(stop);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp_d, input logic [2:0] exp_err);
    int n = 0;
    while (!rd_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk({req, " valid"}, {7'd0, rd_valid}, 8'd1);
    chk({req, " data"}, rd_data, exp_d);
    chk({req, " errbits"}, {5'd0, status[7:5]}, {5'd0, exp_err});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 valid", {7'd0, rd_valid}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 status", status, 8'h0C);
    tx_e = 1'b0;
    @(negedge clk);
    chk("R12 tx bits", status, 8'h04);
    tx_e = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_length;
    cfg_pm = 2'd2;
    for (int l = 0; l < 4; l++) begin
      cfg_len = 2'(l);
      send_frame(8'hB6, 5 + l, 1'b0, 1'b0, 1'b1);
      pop_expect("R2 length", 8'hB6 & 8'((1 << (5 + l)) - 1), 3'b000);
    end
    cfg_len = 2'd3;
    cfg_pm  = 2'd3;
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b1);
    pop_expect("R5 noparity", 8'h81, 3'b000);
  endtask

  task automatic t_parity;
    logic [7:0] d = 8'h3D;
    cfg_pm = 2'd0;
    cfg_odd = 1'b0;
    send_frame(d, 8, 1'b1, ^d, 1'b1);
    pop_expect("R3 even ok", d, 3'b000);
    send_frame(d, 8, 1'b1, ~^d, 1'b1);
    pop_expect("R3 even bad", d, 3'b001);
    cfg_odd = 1'b1;
    send_frame(d, 8, 1'b1, ~^d, 1'b1);
    pop_expect("R3 odd ok", d, 3'b000);
    send_frame(d, 8, 1'b1, ^d, 1'b1);
    pop_expect("R3 odd bad", d, 3'b001);
  endtask

  task automatic t_forced;
    cfg_pm = 2'd1;
    cfg_odd = 1'b1;
    send_frame(8'h01, 8, 1'b1, 1'b1, 1'b1);
    pop_expect("R4 forced high ok", 8'h01, 3'b000);
    send_frame(8'h01, 8, 1'b1, 1'b0, 1'b1);
    pop_expect("R4 forced high bad", 8'h01, 3'b001);
    cfg_odd = 1'b0;
    send_frame(8'h03, 8, 1'b1, 1'b0, 1'b1);
    pop_expect("R4 forced low ok", 8'h03, 3'b000);
    cfg_pm = 2'd2;
  endtask

  task automatic t_framing;
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    pop_expect("R6 framing", 8'h5A, 3'b010);
    repeat (40) @(negedge clk);
    chk("R6 single entry", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R7 glitch ignored", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_break;
    @(negedge clk);
    rxd = 1'b0;
    repeat (30 * BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    pop_expect("R8 break", 8'h00, 3'b110);
    chk("R8 once", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_queue;
    cfg_irqf = 1'b1;
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
    chk("R12 irq full not yet", {7'd0, irq}, 8'd0);
    send_frame(8'h33, 8, 1'b0, 1'b0, 1'b1);
    chk("R12 irq on full", {7'd0, irq}, 8'd1);
    chk("R12 full bit", status, 8'h0F);
    send_frame(8'h44, 8, 1'b0, 1'b0, 1'b1);
    chk("R9 overrun", status, 8'h1F);
    pop_expect("R9 order 1", 8'h11, 3'b000);
    pop_expect("R9 order 2", 8'h22, 3'b000);
    pop_expect("R9 order 3", 8'h33, 3'b000);
    chk("R9 drop", {7'd0, rd_valid}, 8'd0);
    chk("R9 overrun sticky", status, 8'h1C);
    pulse(err_rst);
    chk("R11 err reset ovr", status, 8'h0C);
    cfg_irqf = 1'b0;
    send_frame(8'h55, 8, 1'b0, 1'b0, 1'b1);
    chk("R12 irq avail", {7'd0, irq}, 8'd1);
    pop_expect("R12 pop", 8'h55, 3'b000);
    chk("R12 irq clear", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_modes;
    cfg_pm = 2'd0;
    cfg_odd = 1'b0;
    send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1);
    send_frame(8'h06, 8, 1'b1, 1'b0, 1'b1);
    pop_expect("R10 head bad", 8'h07, 3'b001);
    pop_expect("R10 head good", 8'h06, 3'b000);
    pulse(err_rst);
    cfg_blk = 1'b1;
    send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1);
    send_frame(8'h06, 8, 1'b1, 1'b0, 1'b1);
    pop_expect("R11 block 1", 8'h07, 3'b001);
    pop_expect("R11 block 2", 8'h06, 3'b001);
    chk("R11 sticky empty", status, 8'h2C);
    pulse(err_rst);
    chk("R11 cleared", status, 8'h0C);
    cfg_blk = 1'b0;
    cfg_pm = 2'd2;
    send_frame(8'h99, 8, 1'b0, 1'b0, 1'b1);
    chk("R11 before rxreset", {7'd0, rd_valid}, 8'd1);
    pulse(rx_rst);
    chk("R11 rx reset", status, 8'h0C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_length();
    t_parity();
    t_forced();
    t_framing();
    t_glitch();
    t_break();
    t_queue();
    t_modes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule